// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Edge Strobes

This block turns the system clock into the serial clock of an SPI controller. The divide ratio comes from a 5-bit prescale field with a split encoding. When the top bit of the field is clear, the low four bits are the divisor directly. When the top bit is set, the divisor is twice the low four bits, so the range reaches 30. Divisors below 2 are raised to 2, which keeps every SCLK phase at least one system clock long.

Besides SCLK, the block gives a shift register two single-cycle strobes. The launch strobe marks when the next output bit should be driven. The sample strobe marks when the incoming bit should be captured. CPOL sets the level at which SCLK rests. CPHA chooses which SCLK edge carries the sample and which carries the launch. At the fastest ratio, a capture-shift bit can move sampling into the following system-clock cycle.

Top module: `spi_clk_prescaler`

## Requirements
- R1: The divisor is prescale[3:0] when prescale[4] is 0, and 2*prescale[3:0] when prescale[4] is 1. The SCLK period equals the divisor in system clocks.
- R2: Within each period, SCLK first spends (n+1)/2 cycles at its non-idle level, where n is the divisor and the division rounds down. It then spends n/2 cycles at the idle level, also rounded down. For an odd divisor, the longer part is therefore the non-idle part.
- R3: While run is low, SCLK equals cpol and both strobes are 0. This holds from the first clock edge after run falls.
- R4: A period starts on the first clock edge after run rises, and SCLK leaves its idle level in that cycle (the leading edge). With cpha=0, sample is high in the leading-edge cycle and launch is high in the trailing-edge cycle. With cpha=1 the two are swapped. Each strobe is one clock wide.
- R5: When the effective divisor is 2 and capt_shift is 1, the sample strobe moves one system clock later. It then falls in the other SCLK phase.
- R6: capt_shift has no effect when the effective divisor is greater than 2.
- R7: After reset, SCLK is at its cpol idle level and neither strobe is asserted.
- R8: An encoded divisor of 0 or 1 gives an effective divisor of 2. This includes prescale values 0, 1, 0x10 and 0x11.
- R9: With prescale[4] set, the period is twice the low nibble. For example, 0x1F gives 30 cycles and 0x13 gives 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Clock generation enable |
| prescale | input | 5 | Divisor field; bit 4 selects doubling of bits 3:0 |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| capt_shift | input | 1 | Delay sampling by one system clock at divisor 2 |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe to drive the next output bit |
| sample | output | 1 | One-cycle strobe to capture the input bit |

## Verification
The bench aims at the encoding boundaries. These are the doubled maximum of 30, a doubled field with a zero nibble, and the raw values 0 and 1. A design that decoded bit 4 wrongly, or did not clamp small divisors, would produce the wrong period or a stuck SCLK. Odd divisors are used to expose a duty split placed the wrong way round. Every CPOL/CPHA pairing is run, so swapped launch and sample strobes show up. The capture shift is tested both at divisor 2 and at a larger divisor, so that a shift that never moves, or one that leaks into slower ratios, is caught.

// File: rtl/spi_clk_prescaler.sv
`timescale 1ns/1ps
module spi_clk_prescaler #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] prescale,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          capt_shift,
  output logic          sclk,
  output logic          launch,
  output logic          sample
);
  localparam int LW = PW - 1;

  logic [PW-1:0] div_raw, div, half, cnt, samp_pos;
  logic          en_q, lead, trail, at_min;

  assign div_raw = prescale[PW-1] ? {prescale[LW-1:0], 1'b0}
                                  : {1'b0, prescale[LW-1:0]};
  assign div     = (div_raw < PW'(2)) ? PW'(2) : div_raw;
  assign half    = (div + PW'(1)) >> 1;
  assign at_min  = (div == PW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else if (!run) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= 1'b1;
      if (en_q) cnt <= (cnt >= div - PW'(1)) ? '0 : cnt + PW'(1);
    end
  end

  assign lead     = en_q && (cnt == '0);
  assign trail    = en_q && (cnt == half);
  assign samp_pos = (cpha ? half : PW'(0)) ^ PW'(capt_shift && at_min);

  assign sclk   = cpol ^ (en_q && (cnt < half));
  assign launch = cpha ? lead : trail;
  assign sample = en_q && (cnt == samp_pos);
endmodule

// File: rtl/spi_clk_prescaler_chk.sv
`timescale 1ns/1ps
module spi_clk_prescaler_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [PW-1:0] prescale,
  input logic          cpol,
  input logic          cpha,
  input logic          capt_shift,
  input logic          sclk,
  input logic          launch,
  input logic          sample
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == cpol)) else $error("idle level"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!launch && !sample)) else $error("strobe while stopped"); // R3
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && $stable(prescale) && run) |=> !launch) else $error("launch width"); // R4
  AST_LAUNCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && $stable(cpol)) |-> (sclk != $past(sclk))) else $error("launch off edge"); // R4
  AST_SPLIT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_shift |-> !(launch && sample)) else $error("strobes collide"); // R4
endmodule

bind spi_clk_prescaler spi_clk_prescaler_chk #(.PW(PW)) u_chk (.*);

// File: tb/spi_clk_prescaler_bench.sv
`timescale 1ns/1ps
module spi_clk_prescaler_bench;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [4:0] prescale = 5'd0;
  logic cpol = 1'b0, cpha = 1'b0, capt_shift = 1'b0;
  logic sclk, launch, sample;
  int total = 0, bad = 0;

  typedef struct { logic s; logic l; logic m; string rq; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  spi_clk_prescaler u_spi_clk_prescaler (.*);

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.rq, "sclk", sclk, e.s);
        chk(e.rq, "launch", launch, e.l);
        chk(e.rq, "sample", sample, e.m);
      end
    end
  end

  task automatic drive(input logic [4:0] p, input logic pol, input logic pha,
                       input logic cap, input int periods, input string rq);
    int n, h;
    n = p[4] ? 2 * int'(p[3:0]) : int'(p[3:0]);
    if (n < 2) n = 2;
    h = (n + 1) / 2;
    @(negedge clk);
    prescale = p; cpol = pol; cpha = pha; capt_shift = cap; run = 1'b1;
    @(posedge clk);
    for (int k = 0; k < periods * n; k++) begin
      exp_t e;
      int c, sp;
      c = k % n;
      e.s = pol ^ (c < h);
      e.l = pha ? (c == 0) : (c == h);
      sp = pha ? h : 0;
      if (cap && n == 2) sp = (sp + 1) % 2;
      e.m = (c == sp);
      e.rq = rq;
      q.push_back(e);
    end
    wait (q.size() == 0);
    run = 1'b0;
    @(negedge clk);
    chk("R3", "idle sclk", sclk, pol);
    chk("R3", "idle launch", launch, 1'b0);
    chk("R3", "idle sample", sample, 1'b0);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "reset sclk", sclk, 1'b0);
    chk("R7", "reset launch", launch, 1'b0);
    chk("R7", "reset sample", sample, 1'b0);
    rst_n = 1'b1;
    drive(5'd3,  1'b0, 1'b0, 1'b0, 3, "R2");
    drive(5'd7,  1'b1, 1'b0, 1'b0, 2, "R2");
    drive(5'd4,  1'b1, 1'b1, 1'b0, 3, "R1");
    drive(5'd9,  1'b0, 1'b1, 1'b0, 2, "R4");
    drive(5'd0,  1'b0, 1'b0, 1'b0, 3, "R8");
    drive(5'd1,  1'b1, 1'b1, 1'b0, 3, "R8");
    drive(5'h10, 1'b0, 1'b1, 1'b0, 3, "R8");
    drive(5'h1F, 1'b0, 1'b0, 1'b0, 2, "R9");
    drive(5'h13, 1'b1, 1'b1, 1'b0, 3, "R9");
    drive(5'd2,  1'b0, 1'b0, 1'b1, 3, "R5");
    drive(5'd2,  1'b1, 1'b1, 1'b1, 3, "R5");
    drive(5'd5,  1'b0, 1'b1, 1'b1, 3, "R6");
    drive(5'd6,  1'b1, 1'b0, 1'b1, 2, "R6");
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end
endmodule